// File: doc/BRIEF.md
# Rectangle Copy Blit Engine

The block is a memory-to-memory 2D copy engine. A command stream hands it one packet of eight 32-bit dwords. The packet names a destination rectangle, a source corner, two linear surfaces given by byte base and byte pitch, a pixel depth of 1, 2 or 4 bytes, and an 8-bit ternary raster-operation code. The engine then walks the rectangle in row-major order. For each pixel it reads the source word, reads the destination word, merges the two bit by bit through the raster-op truth table, and writes the result back under byte enables. Each pixel takes three memory cycles.

The source pitch is signed. With a negative pitch each source row lies one pitch below the previous one in memory, so a single command copies the rectangle upside down. At 32 bits per pixel, two command bits enable the top byte (alpha) and the three low bytes (colour) on their own. This allows a channel to be filled or preserved without touching the others. The memory port is word addressed and has no back-pressure. Read data returns on the cycle after the request.

Top module: `blit_engine`

## Requirements
- R1: While idle, `cmd_ready` is high and one dword is accepted on every cycle in which `cmd_valid` is high. On the cycle after the eighth dword is accepted, `busy` is high and `cmd_ready` is low. After reset, `cmd_ready` is 1 and `busy`, `done` and `mem_req` are 0.
- R2: The packet fields are decoded as follows.
  - Dword 0: bit 21 enables the alpha byte and bit 20 enables the colour bytes. All other bits are ignored.
  - Dword 1: destination pitch in bits 15:0, raster-op code in bits 23:16, depth in bits 25:24 (3 = 32 bpp, 1 = 16 bpp, any other value = 8 bpp).
  - Dwords 2 and 3: destination top-left corner (inclusive) and bottom-right corner (exclusive), each packed as y in bits 31:16 and x in bits 15:0.
  - Dword 4: destination byte base.
  - Dword 5: source top-left corner, packed the same way.
  - Dword 6: signed source pitch in bits 15:0.
  - Dword 7: source byte base.
- R3: The pixel at offset (i, j) inside the rectangle is written to byte address dbase + (dy1+j)·dpitch + (dx1+i)·bpp. Its source is at byte address sbase + (sy+j)·spitch + (sx+i)·bpp. Bytes outside the rectangle are never modified. Pixel bytes are little-endian within a word. Read data is taken on the cycle after a read request.
- R4: Each result bit is the bit of the raster-op code indexed by 4 + 2·s + d, where s is the source bit and d is the destination bit. As a result, 0xCC copies, 0x00 clears, 0xFF sets, 0x66 XORs, 0x55 inverts the destination and 0xAA leaves it unchanged.
- R5: At 8 and 16 bpp, exactly the 1 or 2 bytes of the addressed pixel are written, in any lane, and the source pixel is moved from its own lane to the destination lane. At 32 bpp, all four bytes are written, subject to R7.
- R6: A negative source pitch walks the source upward one row per destination row, so the copied rectangle is flipped vertically.
- R7: At 32 bpp, byte 3 of each pixel is written only when the alpha bit is set, and bytes 0 to 2 only when the colour bit is set.
- R8: When x2 ≤ x1 or y2 ≤ y1 (both compared unsigned), no memory request is made.
- R9: `done` pulses for exactly one cycle, with `busy` low, on the (3·N+2)-th cycle after the last dword is accepted, where N is the pixel count. `busy` is high on every cycle between acceptance and that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command dword valid |
| cmd_ready | output | 1 | Engine can take a command dword |
| cmd_data | input | 32 | Command dword |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Word address |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte enables of a write |
| mem_rdata | input | 32 | Read data, one cycle after a read request |
| busy | output | 1 | A command is being executed |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the engine with its default ADDR_W of 16, which gives 18-bit byte arithmetic. This is wide enough for full 16-bit pitches and for a negative pitch to wrap correctly. The memory model decodes only the low 10 word-address bits, so every surface, including a flipped source whose base points at its bottom row, fits in a 4 KB image. That image is compared in full with a byte-level reference after every command. Because of this, a write that strays outside the rectangle or into a masked lane is caught, as well as a wrong pixel value.

// File: rtl/blit_pkg.sv
package blit_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHK,
    ST_RSRC,
    ST_RDST,
    ST_WR,
    ST_FIN
  } blit_state_t;

  // log2 of bytes per pixel from the depth field
  function automatic logic [1:0] depth_shift(input logic [1:0] depth);
    case (depth)
      2'b11:   depth_shift = 2'd2;
      2'b01:   depth_shift = 2'd1;
      default: depth_shift = 2'd0;
    endcase
  endfunction

  // ternary raster op with the pattern input tied high
  function automatic logic [31:0] rop_apply(input logic [7:0] code,
                                            input logic [31:0] s,
                                            input logic [31:0] d);
    for (int i = 0; i < 32; i++) begin
      rop_apply[i] = code[{1'b1, s[i], d[i]}];
    end
  endfunction

endpackage

// File: rtl/blit_decode.sv
module blit_decode #(
  parameter int BW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [31:0]   data,
  output logic          pkt_last,
  output logic          wr_alpha,
  output logic          wr_rgb,
  output logic [15:0]   dpitch,
  output logic [7:0]    rop,
  output logic [1:0]    depth,
  output logic [15:0]   dx1,
  output logic [15:0]   dy1,
  output logic [15:0]   dx2,
  output logic [15:0]   dy2,
  output logic [BW-1:0] dbase,
  output logic [15:0]   sx,
  output logic [15:0]   sy,
  output logic [15:0]   spitch,
  output logic [BW-1:0] sbase
);

  logic [2:0] cnt_q, cnt_n;

  assign pkt_last = load && (cnt_q == 3'd7);
  assign cnt_n    = cnt_q + 3'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= 3'd0;
    end else if (load) begin
      cnt_q <= cnt_n;
    end
  end

  // field capture: datapath registers, no reset
  always_ff @(posedge clk) begin
    if (load) begin
      case (cnt_q)
        3'd0: begin wr_alpha <= data[21]; wr_rgb <= data[20]; end
        3'd1: begin dpitch <= data[15:0]; rop <= data[23:16]; depth <= data[25:24]; end
        3'd2: begin dx1 <= data[15:0]; dy1 <= data[31:16]; end
        3'd3: begin dx2 <= data[15:0]; dy2 <= data[31:16]; end
        3'd4: dbase  <= data[BW-1:0];
        3'd5: begin sx <= data[15:0]; sy <= data[31:16]; end
        3'd6: spitch <= data[15:0];
        default: sbase <= data[BW-1:0];
      endcase
    end
  end

endmodule

// File: rtl/blit_addr.sv
module blit_addr
  import blit_pkg::*;
#(
  parameter int BW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          step,
  input  logic [1:0]    depth,
  input  logic [15:0]   dpitch,
  input  logic [15:0]   dx1,
  input  logic [15:0]   dy1,
  input  logic [15:0]   dx2,
  input  logic [15:0]   dy2,
  input  logic [BW-1:0] dbase,
  input  logic [15:0]   sx,
  input  logic [15:0]   sy,
  input  logic [15:0]   spitch,
  input  logic [BW-1:0] sbase,
  output logic          empty,
  output logic          last_px,
  output logic [BW-1:0] src_byte,
  output logic [BW-1:0] dst_byte
);

  logic [15:0]   xo_q, xo_n, yo_q, yo_n, wid, hgt;
  logic [BW-1:0] srow_q, srow_n, drow_q, drow_n, sp_ext, dp_ext;
  logic [1:0]    sh;
  logic          row_end, en;

  assign sh      = depth_shift(depth);
  assign sp_ext  = {{(BW-16){spitch[15]}}, spitch};
  assign dp_ext  = BW'(dpitch);
  assign wid     = dx2 - dx1;
  assign hgt     = dy2 - dy1;
  assign empty   = (dx2 <= dx1) || (dy2 <= dy1);
  assign row_end = (xo_q == wid - 16'd1);
  assign last_px = row_end && (yo_q == hgt - 16'd1);
  assign en      = start || step;

  always_comb begin
    xo_n   = xo_q;
    yo_n   = yo_q;
    srow_n = srow_q;
    drow_n = drow_q;
    if (start) begin
      xo_n   = 16'd0;
      yo_n   = 16'd0;
      srow_n = sbase + BW'(sy) * sp_ext;
      drow_n = dbase + BW'(dy1) * dp_ext;
    end else if (step) begin
      if (row_end) begin
        xo_n   = 16'd0;
        yo_n   = yo_q + 16'd1;
        srow_n = srow_q + sp_ext;
        drow_n = drow_q + dp_ext;
      end else begin
        xo_n = xo_q + 16'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xo_q   <= '0;
      yo_q   <= '0;
      srow_q <= '0;
      drow_q <= '0;
    end else if (en) begin
      xo_q   <= xo_n;
      yo_q   <= yo_n;
      srow_q <= srow_n;
      drow_q <= drow_n;
    end
  end

  assign src_byte = srow_q + ((BW'(sx) + BW'(xo_q)) << sh);
  assign dst_byte = drow_q + ((BW'(dx1) + BW'(xo_q)) << sh);

endmodule

// File: rtl/blit_lane.sv
module blit_lane
  import blit_pkg::*;
(
  input  logic [31:0] src_word,
  input  logic [31:0] dst_word,
  input  logic [1:0]  s_lane,
  input  logic [1:0]  d_lane,
  input  logic [1:0]  depth,
  input  logic        wr_alpha,
  input  logic        wr_rgb,
  input  logic [7:0]  rop,
  output logic [31:0] wdata,
  output logic [3:0]  be
);

  logic [31:0] src_al, src_pos;

  assign src_al  = src_word >> {s_lane, 3'b000};
  assign src_pos = src_al << {d_lane, 3'b000};
  assign wdata   = rop_apply(rop, src_pos, dst_word);

  always_comb begin
    case (depth_shift(depth))
      2'd2:    be = {wr_alpha, wr_rgb, wr_rgb, wr_rgb};
      2'd1:    be = 4'b0011 << d_lane;
      default: be = 4'b0001 << d_lane;
    endcase
  end

endmodule

// File: rtl/blit_engine.sv
module blit_engine
  import blit_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [31:0]       cmd_data,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  output logic [3:0]        mem_be,
  input  logic [31:0]       mem_rdata,
  output logic              busy,
  output logic              done
);

  localparam int BW = ADDR_W + 2;

  blit_state_t state_q, state_n;
  logic          load, pkt_last, empty, last_px;
  logic          wr_alpha, wr_rgb;
  logic [15:0]   dpitch, dx1, dy1, dx2, dy2, sx, sy, spitch;
  logic [7:0]    rop;
  logic [1:0]    depth;
  logic [BW-1:0] dbase, sbase, src_byte, dst_byte;
  logic [31:0]   src_q, wdata;
  logic [3:0]    be;
  logic          cap_en;

  assign load = cmd_valid && cmd_ready;

  blit_decode #(.BW(BW)) u_dec (
    .clk(clk), .rst_n(rst_n), .load(load), .data(cmd_data),
    .pkt_last(pkt_last), .wr_alpha(wr_alpha), .wr_rgb(wr_rgb),
    .dpitch(dpitch), .rop(rop), .depth(depth),
    .dx1(dx1), .dy1(dy1), .dx2(dx2), .dy2(dy2), .dbase(dbase),
    .sx(sx), .sy(sy), .spitch(spitch), .sbase(sbase)
  );

  blit_addr #(.BW(BW)) u_addr (
    .clk(clk), .rst_n(rst_n),
    .start(state_q == ST_CHK), .step(state_q == ST_WR),
    .depth(depth), .dpitch(dpitch),
    .dx1(dx1), .dy1(dy1), .dx2(dx2), .dy2(dy2), .dbase(dbase),
    .sx(sx), .sy(sy), .spitch(spitch), .sbase(sbase),
    .empty(empty), .last_px(last_px),
    .src_byte(src_byte), .dst_byte(dst_byte)
  );

  blit_lane u_lane (
    .src_word(src_q), .dst_word(mem_rdata),
    .s_lane(src_byte[1:0]), .d_lane(dst_byte[1:0]),
    .depth(depth), .wr_alpha(wr_alpha), .wr_rgb(wr_rgb), .rop(rop),
    .wdata(wdata), .be(be)
  );

  always_comb begin
    state_n = state_q;
    case (state_q)
      ST_IDLE: if (pkt_last) state_n = ST_CHK;
      ST_CHK:  state_n = empty ? ST_FIN : ST_RSRC;
      ST_RSRC: state_n = ST_RDST;
      ST_RDST: state_n = ST_WR;
      ST_WR:   state_n = last_px ? ST_FIN : ST_RSRC;
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_n;
  end

  // source word arrives while the destination read is issued
  assign cap_en = (state_q == ST_RDST);
  always_ff @(posedge clk) begin
    if (cap_en) src_q <= mem_rdata;
  end

  assign cmd_ready = (state_q == ST_IDLE);
  assign busy      = (state_q == ST_CHK) || (state_q == ST_RSRC) ||
                     (state_q == ST_RDST) || (state_q == ST_WR);
  assign done      = (state_q == ST_FIN);
  assign mem_req   = (state_q == ST_RSRC) || (state_q == ST_RDST) || (state_q == ST_WR);
  assign mem_we    = (state_q == ST_WR);
  assign mem_addr  = (state_q == ST_RSRC) ? src_byte[BW-1:2] : dst_byte[BW-1:2];
  assign mem_wdata = wdata;
  assign mem_be    = (state_q == ST_WR) ? be : 4'b0000;

endmodule

// File: rtl/blit_engine_chk.sv
module blit_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_ready,
  input logic busy,
  input logic done,
  input logic mem_req,
  input logic mem_we
);

  p_no_cmd_when_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cmd_ready);

  p_write_follows_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ($past(mem_req) && !$past(mem_we)));

  p_req_only_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_busy_ends_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

endmodule

bind blit_engine blit_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .busy(busy),
  .done(done), .mem_req(mem_req), .mem_we(mem_we)
);

// File: tb/blit_engine_test.sv
`timescale 1ns/1ps
module blit_engine_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic        cmd_ready;
  logic [31:0] cmd_data;
  logic        mem_req, mem_we;
  logic [15:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic [3:0]  mem_be;
  logic        busy, done;

  always #2 clk = ~clk;

  blit_engine uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_data(cmd_data), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_rdata(mem_rdata),
    .busy(busy), .done(done)
  );

  logic [31:0] mem [1024];
  logic [7:0]  refm [4096];
  logic        fill_en;
  logic [9:0]  fill_addr;
  logic [31:0] fill_data;
  int          wr_cnt = 0;
  int          req_cnt = 0;
  int          n_chk = 0, n_fail = 0;
  bit          finished = 0;

  always @(posedge clk) begin
    if (fill_en) begin
      mem[fill_addr] <= fill_data;
    end else if (mem_req) begin
      req_cnt <= req_cnt + 1;
      if (mem_we) begin
        wr_cnt <= wr_cnt + 1;
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) mem[mem_addr[9:0]][8*b +: 8] <= mem_wdata[8*b +: 8];
      end else begin
        mem_rdata <= mem[mem_addr[9:0]];
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] rop_ref(input logic [7:0] code,
                                         input logic [7:0] s, input logic [7:0] d);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = code[4 + 2*s[i] + d[i]];
    return r;
  endfunction

  task automatic run_blit(input string req, input int depth, input bit wa, input bit wrgb,
                          input int rop, input int dpitch,
                          input int dx1, input int dy1, input int dx2, input int dy2,
                          input int dbase, input int sx, input int sy,
                          input int spitch, input int sbase);
    logic [31:0] pk [8];
    int bpp, npx, cyc, w0, r0, bad, badw;
    bit seen_busy, is_empty;
    logic [31:0] expw;
    bpp = (depth == 3) ? 4 : (depth == 1) ? 2 : 1;
    is_empty = (dx2 <= dx1) || (dy2 <= dy1);
    npx = is_empty ? 0 : (dx2 - dx1) * (dy2 - dy1);
    if (!is_empty) begin
      for (int j = 0; j < dy2 - dy1; j++)
        for (int i = 0; i < dx2 - dx1; i++)
          for (int k = 0; k < bpp; k++) begin
            int da, sa;
            bit en;
            da = dbase + (dy1 + j) * dpitch + (dx1 + i) * bpp + k;
            sa = sbase + (sy + j) * spitch + (sx + i) * bpp + k;
            en = (bpp != 4) || ((k == 3) ? wa : wrgb);
            if (en) refm[da] = rop_ref(rop[7:0], refm[sa], refm[da]);
          end
    end
    pk[0] = 32'hA5C0_0006 | (32'(wa) << 21) | (32'(wrgb) << 20);
    pk[1] = (32'(depth) << 24) | (32'(rop[7:0]) << 16) | 32'(dpitch[15:0]);
    pk[2] = {dy1[15:0], dx1[15:0]};
    pk[3] = {dy2[15:0], dx2[15:0]};
    pk[4] = dbase;
    pk[5] = {sy[15:0], sx[15:0]};
    pk[6] = {16'h0, spitch[15:0]};
    pk[7] = sbase;
    w0 = wr_cnt;
    r0 = req_cnt;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      cmd_valid = 1'b1;
      cmd_data  = pk[i];
    end
    cyc = 0;
    seen_busy = 1'b1;
    do begin
      @(negedge clk);
      cmd_valid = 1'b0;
      cyc++;
      if (cyc == 1)
        check(busy && !cmd_ready, "R1", {req, " busy after packet"}, {busy, cmd_ready}, 2'b10);
      else if (!done && !busy) seen_busy = 1'b0;
    end while (!done && cyc < 5000);
    check(cyc == 3 * npx + 2, "R9", {req, " done cycle"}, cyc, 3 * npx + 2);
    check(!busy && seen_busy, "R9", {req, " busy span"}, {busy, seen_busy}, 2'b01);
    @(negedge clk);
    check(!done, "R9", {req, " done one cycle"}, done, 0);
    if (is_empty)
      check(req_cnt == r0, "R8", {req, " no requests"}, req_cnt - r0, 0);
    else
      check(wr_cnt - w0 == npx, "R3", {req, " write count"}, wr_cnt - w0, npx);
    bad = 0;
    badw = 0;
    expw = '0;
    for (int w = 0; w < 1024; w++) begin
      logic [31:0] e;
      e = {refm[4*w+3], refm[4*w+2], refm[4*w+1], refm[4*w]};
      if (e !== mem[w]) begin
        if (bad == 0) begin badw = w; expw = e; end
        bad++;
      end
    end
    check(bad == 0, req, "memory image", mem[badw], expw);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    cmd_valid = 1'b0;
    cmd_data = '0;
    fill_en = 1'b1;
    fill_addr = '0;
    fill_data = '0;
    for (int w = 0; w < 1024; w++) begin
      logic [31:0] v;
      v = $urandom;
      @(negedge clk);
      fill_addr = w[9:0];
      fill_data = v;
      {refm[4*w+3], refm[4*w+2], refm[4*w+1], refm[4*w]} = v;
    end
    @(negedge clk);
    fill_en = 1'b0;
    @(negedge clk);
    check(cmd_ready && !busy && !done && !mem_req, "R1", "reset state",
          {cmd_ready, busy, done, mem_req}, 4'b1000);
    rst_n = 1'b1;
    @(negedge clk);
    check(cmd_ready && !busy && !done && !mem_req, "R1", "after reset",
          {cmd_ready, busy, done, mem_req}, 4'b1000);

    // directed corners: surfaces at 0 (source) and 2048 (destination), pitch 64
    run_blit("R3 copy32",   3, 1, 1, 8'hCC, 64, 2, 1, 6, 4, 2048, 1, 2, 64, 0);
    run_blit("R4 clear",    3, 1, 1, 8'h00, 64, 0, 0, 3, 2, 2048, 0, 0, 64, 0);
    run_blit("R4 set",      3, 1, 1, 8'hFF, 64, 5, 2, 9, 3, 2048, 0, 0, 64, 0);
    run_blit("R4 xor",      3, 1, 1, 8'h66, 64, 1, 3, 5, 6, 2048, 4, 1, 64, 0);
    run_blit("R4 invert",   3, 1, 1, 8'h55, 64, 3, 0, 7, 2, 2048, 0, 0, 64, 0);
    run_blit("R4 keep",     3, 1, 1, 8'hAA, 64, 0, 4, 16, 6, 2048, 0, 0, 64, 0);
    run_blit("R5 copy8",    0, 1, 1, 8'hCC, 64, 3, 1, 13, 3, 2048, 2, 5, 64, 0);
    run_blit("R5 xor16",    1, 1, 1, 8'h66, 64, 1, 2, 7, 4, 2048, 0, 3, 64, 0);
    run_blit("R6 flip",     3, 1, 1, 8'hCC, 64, 0, 0, 4, 5, 2048, 2, 0, -64, 7*64);
    run_blit("R6 flip8",    0, 1, 1, 8'hCC, 64, 5, 2, 11, 6, 2048, 9, 1, -64, 6*64);
    run_blit("R7 alpha",    3, 1, 0, 8'hFF, 64, 0, 0, 8, 3, 2048, 0, 0, 64, 0);
    run_blit("R7 rgb",      3, 0, 1, 8'h00, 64, 4, 3, 10, 5, 2048, 0, 0, 64, 0);
    run_blit("R8 emptyx",   3, 1, 1, 8'hFF, 64, 4, 0, 4, 3, 2048, 0, 0, 64, 0);
    run_blit("R8 emptyy",   1, 1, 1, 8'hFF, 64, 0, 5, 8, 2, 2048, 0, 0, 64, 0);

    // constrained random commands over all depths, codes and pitch signs
    for (int n = 0; n < 30; n++) begin
      int dep, bpp, maxpx, x1, wpx, h, y1, sxx, syy, sp, sb;
      dep   = ($urandom % 3 == 0) ? 0 : ($urandom % 2 == 0) ? 1 : 3;
      bpp   = (dep == 3) ? 4 : (dep == 1) ? 2 : 1;
      maxpx = 64 / bpp;
      x1    = $urandom % maxpx;
      wpx   = 1 + $urandom % (maxpx - x1);
      h     = 1 + $urandom % 8;
      y1    = $urandom % (9 - h);
      sxx   = $urandom % (maxpx - wpx + 1);
      if ($urandom % 2 == 0) begin
        sp = 64; syy = $urandom % (9 - h); sb = 0;
      end else begin
        sp = -64; syy = 0; sb = (h - 1 + $urandom % (9 - h)) * 64;
      end
      run_blit("R2 random", dep, 1'($urandom), 1'($urandom), int'($urandom % 256), 64,
               x1, y1, x1 + wpx, y1 + h, 2048, sxx, syy, sp, sb);
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule